// File: doc/BRIEF.md
# Grouped Command and Status Register for a Packet Network Interface

This block is the single 16-bit command/status word of a simple packet network interface. A processor writes one command word per access. The word is divided into three groups: transmitter, receiver and test. Each group carries its own active-low decode enable, so one write can change any subset of the groups and leave the others untouched. Bits are numbered most significant first: bit 0 has weight 0x8000.

The register holds the level state of the interface: transmitter on, receiver on, loop-back, single-step, wakeup disable and collision reporting. It also issues one-cycle command strobes to the serialiser: end of packet, countdown wakeup, wait for packet start, single bit clock, forced collision and forced-one input. Three transmit error conditions arrive from the datapath as pulses and are held in sticky flags. A read returns the station host address in the upper byte and the status flags in the lower byte. The host address is sampled from a pin during reset.

Top module: `eth_csr`

## Requirements
- R1: While reset is held and in the first cycle after it, every level state output is 0, every strobe is 0, and `rd_data_o` equals `{host_addr_i, 8'h00}`.
- R2: A group acts only when its enable bit is written 0: transmitter 0x8000, receiver 0x0800, test 0x0080. A group whose enable bit is 1 keeps its state and issues no strobe.
- R3: Transmitter group: 0x4000 sets transmitter on (1) or off (0). 0x2000 requests an end-of-packet strobe. 0x1000 requests a countdown wakeup strobe.
- R4: Receiver group: 0x0400 sets receiver on or off. When 0x0400 is 1 and 0x0200 is written 0, a wait-for-packet-start strobe is issued.
- R5: Test group levels: 0x0040 sets loop-back, 0x0020 sets single-step, 0x0010 sets wakeup disable, and 0x0001 sets collision reporting.
- R6: Test bit 0x0008 issues a single bit-clock strobe only when single-step (0x0020) is 1 in the same word.
- R7: Test bit 0x0004 written 0 issues a forced-collision strobe. Test bit 0x0002 written 1 issues a forced-one input strobe.
- R8: Every strobe is high for exactly the one cycle after the clock edge that accepts the requesting write.
- R9: `rd_data_o[7:0]` holds, from bit 7 down to bit 0: receiver on, transmitter on, loop-back, transmit collision, wakeups disabled, transmit data late, single-step, and transmit parity error.
- R10: A pulse on a transmit error input sets its sticky flag. A transmitter-group write with 0x4000 = 1 clears all three flags. A pulse in that same cycle wins over the clear. A write that turns the transmitter off does not clear the flags.
- R11: The host address is captured from `host_addr_i` only during reset. Writes and later changes of the pin do not change `rd_data_o[15:8]`.
- R12: A write with all three enable bits at 1 changes no state and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_i | input | 8 | Station host address, sampled during reset |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 16 | Command word |
| tx_coll_i | input | 1 | Transmit collision pulse |
| tx_late_i | input | 1 | Transmit data late pulse |
| tx_parity_i | input | 1 | Transmit FIFO/bus parity error pulse |
| rd_data_o | output | 16 | Host address and status byte |
| tx_on_o | output | 1 | Transmitter enabled |
| rx_on_o | output | 1 | Receiver enabled |
| loopback_o | output | 1 | Loop-back mode |
| single_step_o | output | 1 | Single-step mode |
| wake_dis_o | output | 1 | Task wakeups disabled |
| rpt_coll_o | output | 1 | Report receiver-detected collisions |
| eop_stb_o | output | 1 | Send end of packet |
| cntdn_stb_o | output | 1 | Countdown wakeup request |
| rx_wait_stb_o | output | 1 | Receiver waits for next packet start |
| bit_clk_stb_o | output | 1 | One single-step bit clock |
| force_coll_stb_o | output | 1 | Forced collision indication |
| force_one_stb_o | output | 1 | Force a one into received data |

## Verification
The bench builds the block with its default parameters: an 8-bit host address, a 16-bit word and three sticky error flags. That is the only width at which the fixed status-byte layout and the group bit positions are defined. With these values the bench can use the canned single-group command words, mixed words that enable all three groups, and the word with all enables set. It can also drive error pulses that coincide with a clearing write, and re-enter reset with a different host address.

// File: rtl/eth_csr_pkg.sv
// Package: shared widths, bit weights and the decoded-command record for
// the grouped command/status register. Bit positions below are LSB-based
// indices of the 16-bit word (index 15 is the word's most significant bit).
package eth_csr_pkg;

    localparam int CSR_W   = 16;
    localparam int HOST_W  = CSR_W / 2;
    localparam int NUM_ERR = 3;
    localparam int NUM_STB = 6;

    // Group enables (active low)
    localparam int B_TX_EN  = 15;
    localparam int B_RX_EN  = 11;
    localparam int B_TST_EN = 7;

    // Transmitter group
    localparam int B_TX_ON  = 14;
    localparam int B_TX_EOP = 13;
    localparam int B_TX_CNT = 12;

    // Receiver group
    localparam int B_RX_ON   = 10;
    localparam int B_RX_WAIT = 9;   // active low

    // Test group
    localparam int B_LOOP   = 6;
    localparam int B_SSTEP  = 5;
    localparam int B_WAKED  = 4;
    localparam int B_BITCLK = 3;
    localparam int B_COLL   = 2;    // active low
    localparam int B_FORCE1 = 1;
    localparam int B_RPTCOL = 0;

    // Strobe vector indices
    localparam int S_EOP    = 0;
    localparam int S_CNT    = 1;
    localparam int S_RXWAIT = 2;
    localparam int S_BITCLK = 3;
    localparam int S_COLL   = 4;
    localparam int S_FORCE1 = 5;

    // Sticky error indices
    localparam int E_COLL   = 0;
    localparam int E_LATE   = 1;
    localparam int E_PARITY = 2;

    typedef struct packed {
        logic tx_we;
        logic tx_on;
        logic rx_we;
        logic rx_on;
        logic tst_we;
        logic loopback;
        logic sstep;
        logic wake_dis;
        logic rpt_coll;
        logic err_clr;
        logic [NUM_STB-1:0] stb_req;
    } csr_cmd_t;

    typedef struct packed {
        logic tx_on;
        logic rx_on;
        logic loopback;
        logic sstep;
        logic wake_dis;
        logic rpt_coll;
    } csr_mode_t;

endpackage

// File: rtl/eth_csr_decode.sv
// Module: eth_csr_decode
// Purpose: combinational decode of one command word into per-group write
// enables, new level values, strobe requests and the sticky-error clear.
// Assumes: wr_en_i qualifies wr_data_i for exactly one cycle per write.
module eth_csr_decode
    import eth_csr_pkg::*;
(
    input  logic             wr_en_i,
    input  logic [CSR_W-1:0] wr_data_i,
    output csr_cmd_t         cmd_o
);

    logic tx_sel;
    logic rx_sel;
    logic tst_sel;

    // Group selects: a group is acted on only when its enable bit is 0
    always_comb begin
        tx_sel  = wr_en_i & ~wr_data_i[B_TX_EN];
        rx_sel  = wr_en_i & ~wr_data_i[B_RX_EN];
        tst_sel = wr_en_i & ~wr_data_i[B_TST_EN];
    end

    // Field extraction and strobe request formation
    always_comb begin
        cmd_o          = '0;
        cmd_o.tx_we    = tx_sel;
        cmd_o.tx_on    = wr_data_i[B_TX_ON];
        cmd_o.rx_we    = rx_sel;
        cmd_o.rx_on    = wr_data_i[B_RX_ON];
        cmd_o.tst_we   = tst_sel;
        cmd_o.loopback = wr_data_i[B_LOOP];
        cmd_o.sstep    = wr_data_i[B_SSTEP];
        cmd_o.wake_dis = wr_data_i[B_WAKED];
        cmd_o.rpt_coll = wr_data_i[B_RPTCOL];
        cmd_o.err_clr  = tx_sel & wr_data_i[B_TX_ON];

        cmd_o.stb_req[S_EOP]    = tx_sel & wr_data_i[B_TX_EOP];
        cmd_o.stb_req[S_CNT]    = tx_sel & wr_data_i[B_TX_CNT];
        cmd_o.stb_req[S_RXWAIT] = rx_sel & wr_data_i[B_RX_ON]
                                         & ~wr_data_i[B_RX_WAIT];
        cmd_o.stb_req[S_BITCLK] = tst_sel & wr_data_i[B_BITCLK]
                                          & wr_data_i[B_SSTEP];
        cmd_o.stb_req[S_COLL]   = tst_sel & ~wr_data_i[B_COLL];
        cmd_o.stb_req[S_FORCE1] = tst_sel & wr_data_i[B_FORCE1];
    end

endmodule

// File: rtl/eth_csr_mode_regs.sv
// Module: eth_csr_mode_regs
// Purpose: holds the level mode state, updating each group only on its own
// select, and captures the host address while reset is asserted.
// Assumes: synchronous active-low reset; host pin is stable during reset.
module eth_csr_mode_regs
    import eth_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOST_W-1:0] host_addr_i,
    input  csr_cmd_t          cmd_i,
    output csr_mode_t         mode_o,
    output logic [HOST_W-1:0] host_o
);

    csr_mode_t         mode_q;
    logic [HOST_W-1:0] host_q;

    // Transmitter group state
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q.tx_on <= 1'b0;
        else if (cmd_i.tx_we) mode_q.tx_on <= cmd_i.tx_on;
    end

    // Receiver group state
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q.rx_on <= 1'b0;
        else if (cmd_i.rx_we) mode_q.rx_on <= cmd_i.rx_on;
    end

    // Test group level state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.loopback <= 1'b0;
            mode_q.sstep    <= 1'b0;
            mode_q.wake_dis <= 1'b0;
            mode_q.rpt_coll <= 1'b0;
        end else if (cmd_i.tst_we) begin
            mode_q.loopback <= cmd_i.loopback;
            mode_q.sstep    <= cmd_i.sstep;
            mode_q.wake_dis <= cmd_i.wake_dis;
            mode_q.rpt_coll <= cmd_i.rpt_coll;
        end
    end

    // Host address: loaded during reset only, read-only afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) host_q <= host_addr_i;
    end

    assign mode_o = mode_q;
    assign host_o = host_q;

endmodule

// File: rtl/eth_csr_strobes.sv
// Module: eth_csr_strobes
// Purpose: registers each strobe request so it is high for the one cycle
// that follows the accepting write edge.
// Assumes: requests are already qualified by the write enable.
module eth_csr_strobes #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] stb_o
);

    for (genvar g = 0; g < N; g++) begin : g_stb
        logic stb_q;
        // One-cycle pulse per request
        always_ff @(posedge clk) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= req_i[g];
        end
        assign stb_o[g] = stb_q;
    end

endmodule

// File: rtl/eth_csr_sticky.sv
// Module: eth_csr_sticky
// Purpose: sticky error flags, set by datapath pulses and cleared by a
// transmitter-on command; a set pulse in the clearing cycle wins.
// Assumes: pulses are synchronous to clk.
module eth_csr_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        // Set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[g]) flag_q <= 1'b1;
            else if (clr_i)    flag_q <= 1'b0;
        end
        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/eth_csr.sv
// Module: eth_csr (top)
// Purpose: grouped command/status register of a packet network interface.
// One write may update transmitter, receiver and test groups selectively;
// reads return the host address above the status byte.
// Assumes: synchronous active-low reset; error inputs are one-cycle pulses.
module eth_csr
    import eth_csr_pkg::*;
#(
    parameter int HOST_BITS = HOST_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HOST_BITS-1:0]   host_addr_i,
    input  logic                   wr_en_i,
    input  logic [2*HOST_BITS-1:0] wr_data_i,
    input  logic                   tx_coll_i,
    input  logic                   tx_late_i,
    input  logic                   tx_parity_i,
    output logic [2*HOST_BITS-1:0] rd_data_o,
    output logic                   tx_on_o,
    output logic                   rx_on_o,
    output logic                   loopback_o,
    output logic                   single_step_o,
    output logic                   wake_dis_o,
    output logic                   rpt_coll_o,
    output logic                   eop_stb_o,
    output logic                   cntdn_stb_o,
    output logic                   rx_wait_stb_o,
    output logic                   bit_clk_stb_o,
    output logic                   force_coll_stb_o,
    output logic                   force_one_stb_o
);

    csr_cmd_t           cmd;
    csr_mode_t          mode;
    logic [HOST_W-1:0]  host;
    logic [NUM_STB-1:0] stb;
    logic [NUM_ERR-1:0] err_set;
    logic [NUM_ERR-1:0] err;

    eth_csr_decode u_dec (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd)
    );

    eth_csr_mode_regs u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr_i (host_addr_i),
        .cmd_i       (cmd),
        .mode_o      (mode),
        .host_o      (host)
    );

    eth_csr_strobes #(.N(NUM_STB)) u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (cmd.stb_req),
        .stb_o (stb)
    );

    // Error pulse vector assembly
    always_comb begin
        err_set           = '0;
        err_set[E_COLL]   = tx_coll_i;
        err_set[E_LATE]   = tx_late_i;
        err_set[E_PARITY] = tx_parity_i;
    end

    eth_csr_sticky #(.N(NUM_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cmd.err_clr),
        .set_i  (err_set),
        .flag_o (err)
    );

    // Read word: host address over the status byte
    always_comb begin
        rd_data_o = {host, mode.rx_on, mode.tx_on, mode.loopback, err[E_COLL],
                     mode.wake_dis, err[E_LATE], mode.sstep, err[E_PARITY]};
    end

    assign tx_on_o          = mode.tx_on;
    assign rx_on_o          = mode.rx_on;
    assign loopback_o       = mode.loopback;
    assign single_step_o    = mode.sstep;
    assign wake_dis_o       = mode.wake_dis;
    assign rpt_coll_o       = mode.rpt_coll;
    assign eop_stb_o        = stb[S_EOP];
    assign cntdn_stb_o      = stb[S_CNT];
    assign rx_wait_stb_o    = stb[S_RXWAIT];
    assign bit_clk_stb_o    = stb[S_BITCLK];
    assign force_coll_stb_o = stb[S_COLL];
    assign force_one_stb_o  = stb[S_FORCE1];

endmodule

// File: rtl/eth_csr_checker.sv
// Module: eth_csr_checker
// Purpose: temporal properties of the register, bound onto eth_csr.
module eth_csr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic [15:0] wr_data_i,
    input logic        tx_coll_i,
    input logic [15:0] rd_data_o,
    input logic        tx_on_o,
    input logic        rx_on_o,
    input logic        loopback_o,
    input logic        single_step_o,
    input logic        wake_dis_o,
    input logic        rpt_coll_o,
    input logic        eop_stb_o,
    input logic        cntdn_stb_o,
    input logic        rx_wait_stb_o,
    input logic        bit_clk_stb_o,
    input logic        force_coll_stb_o,
    input logic        force_one_stb_o
);

    logic [5:0] stbs;
    logic [5:0] lvls;
    assign stbs = {eop_stb_o, cntdn_stb_o, rx_wait_stb_o, bit_clk_stb_o,
                   force_coll_stb_o, force_one_stb_o};
    assign lvls = {tx_on_o, rx_on_o, loopback_o, single_step_o, wake_dis_o,
                   rpt_coll_o};

    assert_tx_follows_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[15]) |=> (tx_on_o == $past(wr_data_i[14])));

    assert_bitclk_needs_sstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk_stb_o |-> single_step_o);

    assert_strobe_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|stbs) |-> $past(wr_en_i));

    assert_sticky_set_by_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[4]) |-> $past(tx_coll_i));

    assert_host_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(rd_data_o[15:8]));

    assert_idle_write_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[15] && wr_data_i[11] && wr_data_i[7])
        |=> ($stable(lvls) && stbs == 6'b0));

endmodule

bind eth_csr eth_csr_checker chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en_i          (wr_en_i),
    .wr_data_i        (wr_data_i),
    .tx_coll_i        (tx_coll_i),
    .rd_data_o        (rd_data_o),
    .tx_on_o          (tx_on_o),
    .rx_on_o          (rx_on_o),
    .loopback_o       (loopback_o),
    .single_step_o    (single_step_o),
    .wake_dis_o       (wake_dis_o),
    .rpt_coll_o       (rpt_coll_o),
    .eop_stb_o        (eop_stb_o),
    .cntdn_stb_o      (cntdn_stb_o),
    .rx_wait_stb_o    (rx_wait_stb_o),
    .bit_clk_stb_o    (bit_clk_stb_o),
    .force_coll_stb_o (force_coll_stb_o),
    .force_one_stb_o  (force_one_stb_o)
);

// File: tb/eth_csr_tb.sv
// Directed bench for eth_csr: one task per scenario, each checking itself
// against a shadow model built from the requirements.
module eth_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = 8'hA5;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic        p_coll = 1'b0, p_late = 1'b0, p_par = 1'b0;
    logic [15:0] rd_data;
    logic        tx_on, rx_on, lb, ss, wd, rc;
    logic        s_eop, s_cnt, s_rxw, s_bclk, s_coll, s_one;

    int checks = 0;
    int errors = 0;

    // shadow model
    logic [7:0] m_host;
    logic m_tx, m_rx, m_lb, m_ss, m_wd, m_rc;
    logic m_ecoll, m_elate, m_epar;

    always #10 clk = ~clk;

    eth_csr dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .tx_coll_i(p_coll), .tx_late_i(p_late), .tx_parity_i(p_par),
        .rd_data_o(rd_data), .tx_on_o(tx_on), .rx_on_o(rx_on),
        .loopback_o(lb), .single_step_o(ss), .wake_dis_o(wd),
        .rpt_coll_o(rc), .eop_stb_o(s_eop), .cntdn_stb_o(s_cnt),
        .rx_wait_stb_o(s_rxw), .bit_clk_stb_o(s_bclk),
        .force_coll_stb_o(s_coll), .force_one_stb_o(s_one)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        return {m_host, m_rx, m_tx, m_lb, m_ecoll, m_wd, m_elate, m_ss, m_epar};
    endfunction

    function automatic logic [5:0] stbv();
        return {s_eop, s_cnt, s_rxw, s_bclk, s_coll, s_one};
    endfunction

    function automatic logic [5:0] lvlv();
        return {tx_on, rx_on, lb, ss, wd, rc};
    endfunction

    function automatic logic [5:0] m_lvl();
        return {m_tx, m_rx, m_lb, m_ss, m_wd, m_rc};
    endfunction

    // update shadow model for a write (R2..R5, R10 clear)
    task automatic model_write(input logic [15:0] d);
        if (!d[15]) begin
            m_tx = d[14];
            if (d[14]) begin m_ecoll = 0; m_elate = 0; m_epar = 0; end
        end
        if (!d[11]) m_rx = d[10];
        if (!d[7]) begin
            m_lb = d[6]; m_ss = d[5]; m_wd = d[4]; m_rc = d[0];
        end
    endtask

    // one write; sample state and strobes after the edge, then strobes gone
    task automatic do_write(input logic [15:0] d, input logic [5:0] exp_stb,
                            input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #5;
        model_write(d);
        check(stbv() == exp_stb, req, {10'd0, stbv()}, {10'd0, exp_stb});
        check(lvlv() == m_lvl(), req, {10'd0, lvlv()}, {10'd0, m_lvl()});
        check(rd_data == exp_rd(), "R9", rd_data, exp_rd());
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0000;
        @(posedge clk); #5;
        check(stbv() == 6'b0, "R8", {10'd0, stbv()}, 16'h0000);
    endtask

    task automatic apply_reset(input logic [7:0] h);
        @(negedge clk);
        rst_n = 1'b0; host_addr = h;
        repeat (3) @(posedge clk);
        #5;
        m_host = h; m_tx = 0; m_rx = 0; m_lb = 0; m_ss = 0; m_wd = 0; m_rc = 0;
        m_ecoll = 0; m_elate = 0; m_epar = 0;
        check(rd_data == exp_rd() && lvlv() == 6'b0 && stbv() == 6'b0, "R1 in reset",
              rd_data, exp_rd());
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(rd_data == exp_rd() && lvlv() == 6'b0 && stbv() == 6'b0, "R1 after reset",
              rd_data, exp_rd());
    endtask

    // strobe order in stbv(): {eop, cnt, rxwait, bitclk, coll, one}
    task automatic t_tx();
        do_write(16'h4FFF, 6'b000000, "R3 tx on");
        do_write(16'h6FFF, 6'b100000, "R3 eop");
        do_write(16'h5FFF, 6'b010000, "R3 countdown");
        do_write(16'h0FFF, 6'b000000, "R3 tx off");
    endtask

    task automatic t_rx();
        do_write(16'hF6FF, 6'b000000, "R4 rx on no wait");
        do_write(16'hF4FF, 6'b001000, "R4 rx wait start");
        do_write(16'hF0FF, 6'b000000, "R4 rx off");
    endtask

    task automatic t_test_levels();
        do_write(16'hFF55, 6'b000000, "R5 loop/wake/report");
        do_write(16'hFF24, 6'b000000, "R5 single-step only");
    endtask

    task automatic t_bitclk();
        do_write(16'hFF0C, 6'b000000, "R6 bitclk without sstep");
        do_write(16'hFF2C, 6'b000100, "R6 bitclk with sstep");
    endtask

    task automatic t_force();
        do_write(16'hFF00, 6'b000010, "R7 forced collision");
        do_write(16'hFF06, 6'b000001, "R7 force one");
    endtask

    task automatic t_groups();
        do_write(16'h0644, 6'b000000, "R2 all groups");
        do_write(16'hC0FF, 6'b000000, "R2 rx only, tx kept");
        do_write(16'h4FFF, 6'b000000, "R2 tx only");
        do_write(16'hFFFF, 6'b000000, "R12 all disabled");
        do_write(16'hFFFF & ~16'h0000, 6'b000000, "R12 repeat");
    endtask

    task automatic pulse(input logic c, input logic l, input logic p,
                         input logic wr, input logic [15:0] d);
        @(negedge clk);
        p_coll = c; p_late = l; p_par = p;
        wr_en = wr; wr_data = d;
        @(posedge clk); #5;
        if (wr) model_write(d);
        if (c) m_ecoll = 1;
        if (l) m_elate = 1;
        if (p) m_epar = 1;
        check(rd_data == exp_rd(), "R10", rd_data, exp_rd());
        @(negedge clk);
        p_coll = 0; p_late = 0; p_par = 0; wr_en = 0; wr_data = 16'h0;
        @(posedge clk); #5;
    endtask

    task automatic t_sticky();
        pulse(1, 0, 0, 0, 16'h0);
        pulse(0, 1, 1, 0, 16'h0);
        repeat (3) @(posedge clk);
        #5;
        check(rd_data == exp_rd(), "R10 held", rd_data, exp_rd());
        do_write(16'h0FFF, 6'b000000, "R10 tx off keeps flags");
        check(rd_data[4] && rd_data[2] && rd_data[0], "R10 flags kept",
              rd_data, exp_rd());
        do_write(16'h4FFF, 6'b000000, "R10 tx on clears");
        check(rd_data[4] == 0 && rd_data[2] == 0 && rd_data[0] == 0, "R10 cleared",
              rd_data, exp_rd());
        pulse(1, 0, 0, 1, 16'h4FFF);
        check(rd_data[4] == 1, "R10 pulse wins over clear", rd_data, exp_rd());
    endtask

    task automatic t_host();
        @(negedge clk);
        host_addr = 8'h3C;
        do_write(16'h0644, 6'b000000, "R11 write");
        check(rd_data[15:8] == 8'hA5, "R11 host kept", {8'd0, rd_data[15:8]}, 16'h00A5);
        apply_reset(8'h3C);
        check(rd_data[15:8] == 8'h3C, "R11 host reloaded", {8'd0, rd_data[15:8]}, 16'h003C);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apply_reset(8'hA5);
        t_tx();
        t_rx();
        t_test_levels();
        t_bitclk();
        t_force();
        t_groups();
        t_sticky();
        t_host();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule